// File: doc/BRIEF.md
# PWM Input Capture Unit

This block measures a pulse-width-modulated waveform on one of two input pins. A prescaler divides the system clock into ticks, and a 16-bit counter counts those ticks. Each active edge of the selected pin restarts the counter and the prescaler. At that edge the counter value is latched as the period. The opposite edge on the same pin latches the counter value as the active-level width. Software reads both results through a small register port and can be interrupted when a capture completes or when the counter wraps.

The two capture channels swap roles with the selected pin. A polarity bit chooses whether the rising or the falling edge starts a period. Any write to the control or prescaler register clears the counter, the captures and the status flags, so a new configuration always starts from a clean state.

Top module: `pwm_capture_unit`

## Requirements
- R1: After reset every register reads zero and `irq` is low. Register addresses: 0 control, 1 prescaler, 2 interrupt enable, 3 status, 4 capture A, 5 capture B.
- R2: With prescaler value N, a capture equals floor(C/(N+1)) mod 2^16, where C is the number of clock cycles from the restarting active edge to the captured edge.
- R3: With control bit 1 (pin select) at 0, pin 0 is measured: capture A holds the period and capture B holds the width.
- R4: With pin select at 1, pin 1 is measured: capture B holds the period and capture A holds the width. Edges on the unselected pin have no effect.
- R5: Control bit 2 (polarity) at 0 makes the rising edge active. At 1 the falling edge is active, and the width is the low time.
- R6: A load of capture A sets status bit 0, and a load of capture B sets status bit 1.
- R7: Status bit 2 is set only when a tick takes the counter from 0xFFFF to 0. A restart by an active edge never sets it.
- R8: `irq` is high exactly when some status bit and the enable bit at the same position are both 1.
- R9: A write to status clears every flag whose bit is written as 0 and keeps the others. Writing zero clears all flags.
- R10: Writing control with bit 0 (run) at 0 clears the status flags and the interrupt enables. While run is 0 the counter holds still and no capture or flag occurs.
- R11: Any write to the control or prescaler register zeroes the counter, the prescaler, both captures and the status.
- R12: A capture keeps its value until its next load. Reads have no side effects, and writes to the capture addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_in | input | 2 | Asynchronous measured pins |
| reg_wr | input | 1 | Write strobe for the register at `reg_addr` |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a 16-bit prescaler and a two-stage synchronizer. With these values, a wrap at prescaler 0 takes 65,536 cycles, so the overflow flag can be observed directly, both just before and just after the wrap. Prescalers of 0 and 3 show both exact and truncated tick counts. Waveforms on both pins and in both polarities show the channel swap and the width taken from the opposite edge.

// File: rtl/pwmcap_pkg.sv
// Shared register addresses, control layout and status bit positions for the
// PWM capture unit. Assumes a 3-bit register address space.
package pwmcap_pkg;

    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_PRESC  = 3'd1,
        RA_IEN    = 3'd2,
        RA_STATUS = 3'd3,
        RA_CAPA   = 3'd4,
        RA_CAPB   = 3'd5,
        RA_RSV6   = 3'd6,
        RA_RSV7   = 3'd7
    } reg_sel_e;

    // Control register, bit 0 is run, bit 1 pin select, bit 2 polarity.
    typedef struct packed {
        logic pol;
        logic sel;
        logic run;
    } ctrl_t;

    localparam int NFLAG  = 3;
    localparam int ST_CAPA = 0;
    localparam int ST_CAPB = 1;
    localparam int ST_OVF  = 2;

endpackage

// File: rtl/pwmcap_edge_det.sv
// Synchronizes one asynchronous pin through STAGES flops and flags its rising
// and falling transitions for one cycle each. Assumes STAGES >= 2.
module pwmcap_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] shift_q;

    // Shift the pin through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[STAGES-1:0], pin};
    end

    // Compare the settled sample with the one before it.
    always_comb begin
        rise = shift_q[STAGES-1] & ~shift_q[STAGES];
        fall = ~shift_q[STAGES-1] & shift_q[STAGES];
    end

endmodule

// File: rtl/pwmcap_prescaler.sv
// Divides the clock into ticks: one tick every (psc+1) cycles while run is
// high. Clear and restart zero the divider. Assumes psc changes only together
// with clear.
module pwmcap_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             restart,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    logic [PSC_W-1:0] div_q;

    // Tick when the divider reaches the programmed terminal value.
    always_comb tick = run && (div_q == psc);

    // Advance the divider, wrapping on a tick and zeroing on restart.
    always_ff @(posedge clk) begin
        if (!rst_n)              div_q <= '0;
        else if (clr || restart) div_q <= '0;
        else if (run)            div_q <= tick ? '0 : div_q + 1'b1;
    end

    p_div_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= psc);

endmodule

// File: rtl/pwmcap_timebase.sv
// Tick counter with edge restart and NCH capture registers. A capture takes
// the count including a tick that lands in the same cycle. Assumes tick is
// already gated by run.
module pwmcap_timebase #(
    parameter int CNT_W = 16,
    parameter int NCH   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    input  logic                      clr,
    input  logic                      tick,
    input  logic                      restart,
    input  logic [NCH-1:0]            ld,
    output logic [CNT_W-1:0]          cnt_q,
    output logic [NCH-1:0][CNT_W-1:0] cap_q,
    output logic                      wrap_evt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cap_val;

    // Value that a capture latches in this cycle.
    always_comb cap_val = cnt_q + CNT_W'(tick);

    // Wrap event only from counting past the maximum, never from a restart.
    always_comb wrap_evt = run && tick && (cnt_q == CNT_MAX) && !restart && !clr;

    // Count ticks, restarting from zero on an active edge or a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (clr)              cnt_q <= '0;
        else if (run && restart)   cnt_q <= '0;
        else if (tick)             cnt_q <= cnt_q + 1'b1;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_cap
        // Hold one capture value until its channel loads again.
        always_ff @(posedge clk) begin
            if (!rst_n)              cap_q[c] <= '0;
            else if (clr)            cap_q[c] <= '0;
            else if (run && ld[c])   cap_q[c] <= cap_val;
        end

        p_cap_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && !(run && ld[c])) |=> $stable(cap_q[c]));
    end

    p_restart_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && restart && !clr) |=> (cnt_q == '0));

    p_idle_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/pwm_capture_unit.sv
// PWM input capture unit: measures the period and width of a pulse train on
// one of two asynchronous pins, in ticks of a programmable prescaler. Assumes
// CNT_W and PSC_W do not exceed DATA_W.
module pwm_capture_unit #(
    parameter int CNT_W       = 16,
    parameter int PSC_W       = 16,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pwm_in,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    import pwmcap_pkg::*;

    localparam int NPIN = 2;
    localparam int NCH  = 2;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    reg_sel_e                  addr_s;
    ctrl_t                     ctrl_q;
    logic [PSC_W-1:0]          psc_q;
    logic [NFLAG-1:0]          ien_q;
    logic [NFLAG-1:0]          stat_q;
    logic [NFLAG-1:0]          set_v;
    logic                      cfg_wr;
    logic [NPIN-1:0]           rise, fall;
    logic                      pin_rise, pin_fall, act_e, opp_e;
    logic [NCH-1:0]            ld;
    logic                      tick, wrap_evt;
    logic [CNT_W-1:0]          cnt_q;
    logic [NCH-1:0][CNT_W-1:0] cap_q;

    always_comb addr_s = reg_sel_e'(reg_addr);

    // A write to control or prescaler restarts measurement from zero.
    always_comb cfg_wr = reg_wr && (addr_s == RA_CTRL || addr_s == RA_PRESC);

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        pwmcap_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pwm_in[p]),
            .rise  (rise[p]),
            .fall  (fall[p])
        );
    end

    // Pick the measured pin, classify its edges and route them to channels.
    always_comb begin
        pin_rise = rise[ctrl_q.sel];
        pin_fall = fall[ctrl_q.sel];
        act_e    = ctrl_q.run & (ctrl_q.pol ? pin_fall : pin_rise);
        opp_e    = ctrl_q.run & (ctrl_q.pol ? pin_rise : pin_fall);
        ld[0]    = ctrl_q.sel ? opp_e : act_e;
        ld[1]    = ctrl_q.sel ? act_e : opp_e;
    end

    pwmcap_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_q.run),
        .clr     (cfg_wr),
        .restart (act_e),
        .psc     (psc_q),
        .tick    (tick)
    );

    pwmcap_timebase #(.CNT_W(CNT_W), .NCH(NCH)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl_q.run),
        .clr      (cfg_wr),
        .tick     (tick),
        .restart  (act_e),
        .ld       (ld),
        .cnt_q    (cnt_q),
        .cap_q    (cap_q),
        .wrap_evt (wrap_evt)
    );

    // Configuration registers: control, prescaler and interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            psc_q  <= '0;
            ien_q  <= '0;
        end else if (reg_wr) begin
            if (addr_s == RA_CTRL) begin
                ctrl_q <= ctrl_t'(reg_wdata[2:0]);
                if (!reg_wdata[0]) ien_q <= '0;
            end
            if (addr_s == RA_PRESC) psc_q <= reg_wdata[PSC_W-1:0];
            if (addr_s == RA_IEN)   ien_q <= reg_wdata[NFLAG-1:0];
        end
    end

    // Events that raise status flags this cycle.
    always_comb begin
        set_v          = '0;
        set_v[ST_CAPA] = ld[0];
        set_v[ST_CAPB] = ld[1];
        set_v[ST_OVF]  = wrap_evt;
    end

    // Status flags: set by events, cleared by zero bits written or by reconfig.
    always_ff @(posedge clk) begin
        if (!rst_n)      stat_q <= '0;
        else if (cfg_wr) stat_q <= '0;
        else if (reg_wr && addr_s == RA_STATUS)
                         stat_q <= (stat_q & reg_wdata[NFLAG-1:0]) | set_v;
        else             stat_q <= stat_q | set_v;
    end

    // Interrupt request from enabled pending flags.
    always_comb irq = |(stat_q & ien_q);

    // Read multiplexer, free of side effects.
    always_comb begin
        reg_rdata = '0;
        case (addr_s)
            RA_CTRL:   reg_rdata = DATA_W'(ctrl_q);
            RA_PRESC:  reg_rdata = DATA_W'(psc_q);
            RA_IEN:    reg_rdata = DATA_W'(ien_q);
            RA_STATUS: reg_rdata = DATA_W'(stat_q);
            RA_CAPA:   reg_rdata = DATA_W'(cap_q[0]);
            RA_CAPB:   reg_rdata = DATA_W'(cap_q[1]);
            default:   reg_rdata = '0;
        endcase
    end

    p_ovf_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[ST_OVF]) |-> ($past(cnt_q) == CNT_MAX && $past(ctrl_q.run)));

    p_disable_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && addr_s == RA_CTRL && !reg_wdata[0]) |=> (stat_q == '0 && ien_q == '0));

    p_status_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && addr_s == RA_STATUS && reg_wdata[NFLAG-1:0] == '0 && set_v == '0)
        |=> (stat_q == '0));

endmodule

// File: tb/tb_pwm_capture_unit.sv
// Directed bench for the PWM capture unit: one task per scenario.
module tb_pwm_capture_unit;
    localparam int DATA_W = 16;
    localparam realtime CYC = 8ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        pins = 2'b00;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_addr = 3'd0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CYC/2) clk = ~clk;

    pwm_capture_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_in    (pins),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = DATA_W'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        reg_addr = 3'(a);
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic chk_reg(input string req, input int a, input int exp);
        int v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic chk_irq(input string req, input int exp);
        @(negedge clk);
        #1;
        check(req, int'(irq), exp);
    endtask

    // Drive n periods: active level for act_len cycles, then idle.
    task automatic pwm(input int pin, input bit act_lvl, input int act_len,
                       input int per, input int n);
        for (int k = 0; k < n; k++) begin
            pins[pin] = act_lvl;
            repeat (act_len) @(negedge clk);
            pins[pin] = ~act_lvl;
            repeat (per - act_len) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset;
        for (int a = 0; a < 6; a++) chk_reg("R1 reg after reset", a, 0);
        chk_irq("R1 irq after reset", 0);
    endtask

    task automatic t_pin0_high;
        wr(1, 0);
        wr(0, 1);
        pwm(0, 1'b1, 7, 20, 3);
        chk_reg("R3 capA period", 4, 20);
        chk_reg("R3 capB width", 5, 7);
        chk_reg("R6 R7 status caps, no ovf", 3, 3);
    endtask

    task automatic t_prescale;
        wr(1, 3);
        wr(0, 1);
        pwm(0, 1'b1, 11, 42, 3);
        chk_reg("R2 capA 42/4", 4, 10);
        chk_reg("R2 capB 11/4", 5, 2);
    endtask

    task automatic t_pin1;
        wr(1, 0);
        wr(0, 3);
        pwm(1, 1'b1, 5, 16, 3);
        chk_reg("R4 capB period", 5, 16);
        chk_reg("R4 capA width", 4, 5);
        wr(3, 0);
        chk_reg("R9 write zero clears", 3, 0);
        pwm(0, 1'b1, 3, 10, 3);
        chk_reg("R4 pin0 ignored capA", 4, 5);
        chk_reg("R4 pin0 ignored capB", 5, 16);
        chk_reg("R4 pin0 ignored status", 3, 0);
    endtask

    task automatic t_active_low;
        int v1, v2;
        pins[0] = 1'b1;
        repeat (6) @(negedge clk);
        wr(0, 5);
        pwm(0, 1'b0, 9, 24, 3);
        chk_reg("R5 capA period", 4, 24);
        chk_reg("R5 capB low width", 5, 9);
        rd(4, v1);
        rd(4, v2);
        check("R12 repeated read", v2, v1);
        wr(4, 16'h1234);
        chk_reg("R12 write to capA ignored", 4, 24);
        chk_reg("R12 read keeps status", 3, 3);
    endtask

    task automatic t_status_irq;
        chk_irq("R8 no enable", 0);
        wr(2, 2);
        chk_irq("R8 capB enabled", 1);
        wr(3, 6);
        chk_reg("R9 partial clear", 3, 2);
        chk_irq("R8 still pending", 1);
        wr(1, 0);
        chk_reg("R11 capA zeroed", 4, 0);
        chk_reg("R11 capB zeroed", 5, 0);
        chk_reg("R11 status zeroed", 3, 0);
        chk_irq("R8 after clear", 0);
    endtask

    task automatic t_overflow;
        pins[0] = 1'b0;
        repeat (6) @(negedge clk);
        wr(0, 1);
        wr(2, 4);
        repeat (65520) @(negedge clk);
        chk_reg("R7 no flag before wrap", 3, 0);
        repeat (20) @(negedge clk);
        chk_reg("R7 flag after wrap", 3, 4);
        chk_irq("R8 overflow irq", 1);
    endtask

    task automatic t_disable;
        wr(0, 0);
        chk_reg("R10 status cleared", 3, 0);
        chk_reg("R10 enables cleared", 2, 0);
        chk_irq("R10 irq low", 0);
        pwm(0, 1'b1, 4, 12, 3);
        chk_reg("R10 no capA while stopped", 4, 0);
        chk_reg("R10 no capB while stopped", 5, 0);
        chk_reg("R10 no flags while stopped", 3, 0);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(CYC * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pin0_high();
        t_prescale();
        t_pin1();
        t_active_low();
        t_status_irq();
        t_overflow();
        t_disable();
        summary();
        $finish;
    end

endmodule